// File: doc/BRIEF.md
# Format-Aware Pixel Output FIFO

This block sits between an upstream pixel scaler and the output timing logic of a display pipe. It stores whole pixels and keeps its occupancy in bytes. A 16-bit pixel counts as two bytes. An 18-bit or 24-bit pixel counts as three bytes. The timing logic pulls one pixel per read request during active video, and each accepted read returns the pixel one cycle later.

Backpressure is raised before the 64-byte store is physically full. The margin is set by the selected output format so that it covers the pixels still in flight from the upstream pipeline. A software clear empties the store. A clear-at-frame-start option can also empty it when a frame begins. A wait-for-line-start option holds back reads after enable or after any clear until the first line start arrives. When the underflow trigger is enabled, a read attempted on an empty store raises a sticky underflow flag.

Top module: `pix_out_fifo`

## Requirements
- R1: After reset, fill_bytes is 0, underflow is 0, out_valid is 0, and in_ready is 0 while cfg_enable is 0.
- R2: in_ready is 1 exactly when cfg_enable is 1 and fill_bytes is below the threshold. The threshold is 52 for cfg_fmt 2'b00 (16-bit), 50 for 2'b01 (18-bit), and 46 for 2'b10 and 2'b11 (24-bit). With continuous writes this stores 26, 17 and 16 pixels respectively.
- R3: fill_bytes equals the stored pixel count times the bytes per pixel. Bytes per pixel is 2 for cfg_fmt 2'b00 and 3 for every other value. A format change rescales fill_bytes at once.
- R4: Pixels leave in the order they were accepted. out_valid is 1 in the cycle after an accepted read, with out_pixel holding that pixel.
- R5: out_rd is ignored unless both active and cfg_enable are 1. An ignored read leaves fill_bytes unchanged and out_valid low.
- R6: cfg_clear empties the store by the next cycle and clears underflow. A write offered in the same cycle as the clear is dropped.
- R7: With cfg_clr_at_start set to 1, a frame_start pulse empties the store. With it set to 0, frame_start has no effect on the contents.
- R8: A read taken while the store is empty sets underflow only when cfg_underflow_trig is 1. Once set, underflow stays 1 until cfg_clear.
- R9: With cfg_wait_hstart set to 1, reads are ignored after enable or any clear until a line_start pulse has been seen. Ignored reads also raise no underflow.
- R10: While cfg_enable is 0, in_valid is not accepted and fill_bytes stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Enables writes and reads |
| cfg_clear | input | 1 | Software clear of the store and the underflow flag |
| cfg_fmt | input | 2 | Output pixel format select |
| cfg_clr_at_start | input | 1 | Empty the store on frame_start |
| cfg_underflow_trig | input | 1 | Allow empty reads to set underflow |
| cfg_wait_hstart | input | 1 | Hold reads until the first line_start |
| frame_start | input | 1 | Frame start pulse from timing logic |
| line_start | input | 1 | Line start pulse from timing logic |
| active | input | 1 | Active video window |
| in_valid | input | 1 | Upstream pixel offered |
| in_pixel | input | PIX_W | Upstream pixel data |
| in_ready | output | 1 | Store can accept a pixel |
| out_rd | input | 1 | Read request from timing logic |
| out_pixel | output | PIX_W | Pixel returned by the last accepted read |
| out_valid | output | 1 | out_pixel was loaded in the previous cycle |
| fill_bytes | output | FILL_W | Occupancy in bytes |
| underflow | output | 1 | Sticky empty-read flag |

## Verification
Continuous writes are applied under each format until in_ready drops. The number of pixels accepted separates the three thresholds and the two byte weights, and draining those pixels confirms the order. A format switch on a partly filled store shows that fill_bytes is rescaled rather than accumulated. Reads are also offered outside active video, with the block disabled, and before a line start. These show that each gate suppresses both the pop and the underflow flag. The two clear sources are each tested with their option on and off, and the clear is checked against a write in the same cycle.

// File: rtl/pof_pkg.sv
package pof_pkg;
  typedef enum logic [1:0] {
    FMT_RGB16  = 2'd0,
    FMT_RGB18  = 2'd1,
    FMT_RGB24  = 2'd2,
    FMT_RGB24B = 2'd3
  } pof_fmt_e;

  // bytes held per stored pixel
  function automatic logic [1:0] pof_bpp(pof_fmt_e f);
    return (f == FMT_RGB16) ? 2'd2 : 2'd3;
  endfunction
endpackage

// File: rtl/pof_thresh.sv
module pof_thresh #(
  parameter int CAP_BYTES = 64,
  parameter int LAT_PIX   = 6,
  parameter int FILL_W    = 7
) (
  input  logic [1:0]        fmt,
  output logic [1:0]        bpp,
  output logic [FILL_W-1:0] thr
);
  import pof_pkg::*;

  localparam int THR16 = CAP_BYTES - 2*LAT_PIX;
  localparam int THR18 = CAP_BYTES - (2*LAT_PIX + 2);
  localparam int THR24 = CAP_BYTES - 3*LAT_PIX;

  pof_fmt_e f;

  always_comb begin
    f   = pof_fmt_e'(fmt);
    bpp = pof_bpp(f);
    unique case (f)
      FMT_RGB16: thr = FILL_W'(THR16);
      FMT_RGB18: thr = FILL_W'(THR18);
      default:   thr = FILL_W'(THR24);
    endcase
  end
endmodule

// File: rtl/pof_store.sv
module pof_store #(
  parameter int DEPTH = 32,
  parameter int PIX_W = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [PIX_W-1:0] wdata,
  output logic [PIX_W-1:0] rdata,
  output logic [CNT_W-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PIX_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, wptr_n, rptr, rptr_n;
  logic [CNT_W-1:0] cnt_n;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    cnt_n  = count;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (push) wptr_n = bump(wptr);
      if (pop)  rptr_n = bump(rptr);
      case ({push, pop})
        2'b10:   cnt_n = count + 1'b1;
        2'b01:   cnt_n = count - 1'b1;
        default: cnt_n = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      wptr  <= wptr_n;
      rptr  <= rptr_n;
      count <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr] <= wdata;
  end

  assign rdata = mem[rptr];
endmodule

// File: rtl/pof_rdctl.sv
module pof_rdctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic flush,
  input  logic sw_clear,
  input  logic line_start,
  input  logic wait_hstart,
  input  logic trig,
  input  logic rd_req,
  input  logic empty,
  output logic pop,
  output logic underflow
);
  logic armed, armed_n, uf_n, rd_go;

  always_comb begin
    rd_go = rd_req && (!wait_hstart || armed) && !flush;
    pop   = rd_go && !empty;

    if (flush || !enable) armed_n = 1'b0;
    else if (line_start)  armed_n = 1'b1;
    else                  armed_n = armed;

    if (sw_clear)                    uf_n = 1'b0;
    else if (rd_go && empty && trig) uf_n = 1'b1;
    else                             uf_n = underflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      underflow <= 1'b0;
    end else begin
      armed     <= armed_n;
      underflow <= uf_n;
    end
  end
endmodule

// File: rtl/pix_out_fifo.sv
module pix_out_fifo #(
  parameter int CAP_BYTES = 64,
  parameter int LAT_PIX   = 6,
  parameter int PIX_W     = 24,
  parameter int MIN_BPP   = 2,
  parameter int MAX_BPP   = 3,
  localparam int DEPTH    = CAP_BYTES / MIN_BPP,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int FILL_W   = $clog2(DEPTH*MAX_BPP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_clear,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_clr_at_start,
  input  logic              cfg_underflow_trig,
  input  logic              cfg_wait_hstart,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              active,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_pixel,
  output logic              in_ready,
  input  logic              out_rd,
  output logic [PIX_W-1:0]  out_pixel,
  output logic              out_valid,
  output logic [FILL_W-1:0] fill_bytes,
  output logic              underflow
);
  logic [1:0]        bpp;
  logic [FILL_W-1:0] thr;
  logic [CNT_W-1:0]  count;
  logic [PIX_W-1:0]  rdata;
  logic              flush, push, pop, empty, rd_req;
  logic [PIX_W-1:0]  opix_n;
  logic              oval_n;

  pof_thresh #(.CAP_BYTES(CAP_BYTES), .LAT_PIX(LAT_PIX), .FILL_W(FILL_W)) u_thr (
    .fmt(cfg_fmt), .bpp(bpp), .thr(thr)
  );

  always_comb begin
    flush      = cfg_clear || (cfg_clr_at_start && frame_start);
    fill_bytes = FILL_W'(count) * FILL_W'(bpp);
    in_ready   = cfg_enable && (fill_bytes < thr);
    push       = in_valid && in_ready && !flush;
    empty      = (count == '0);
    rd_req     = out_rd && active && cfg_enable;
  end

  pof_store #(.DEPTH(DEPTH), .PIX_W(PIX_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wdata(in_pixel), .rdata(rdata), .count(count)
  );

  pof_rdctl u_rd (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .flush(flush),
    .sw_clear(cfg_clear), .line_start(line_start),
    .wait_hstart(cfg_wait_hstart), .trig(cfg_underflow_trig),
    .rd_req(rd_req), .empty(empty), .pop(pop), .underflow(underflow)
  );

  always_comb begin
    oval_n = pop;
    opix_n = pop ? rdata : out_pixel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pixel <= '0;
    end else begin
      out_valid <= oval_n;
      if (pop) out_pixel <= opix_n;
    end
  end
endmodule

// File: rtl/pix_out_fifo_chk.sv
module pix_out_fifo_chk #(
  parameter int CAP_BYTES = 64,
  parameter int LAT_PIX   = 6,
  parameter int FILL_W    = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic              cfg_clear,
  input logic              cfg_clr_at_start,
  input logic              cfg_underflow_trig,
  input logic              frame_start,
  input logic              active,
  input logic              out_rd,
  input logic              in_ready,
  input logic              out_valid,
  input logic [FILL_W-1:0] fill_bytes,
  input logic              underflow
);
  localparam int MIN_THR = CAP_BYTES - 3*LAT_PIX;

  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (!cfg_enable || fill_bytes >= FILL_W'(MIN_THR)));

  p_ready_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cfg_enable && fill_bytes < FILL_W'(CAP_BYTES)));

  p_gated_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_rd || !active || !cfg_enable) |=> !out_valid);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clear |=> (fill_bytes == '0 && !underflow));

  p_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clr_at_start && frame_start) |=> (fill_bytes == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !cfg_clear) |=> underflow);

  p_trig_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!underflow && !cfg_underflow_trig) |=> !underflow);
endmodule

bind pix_out_fifo pix_out_fifo_chk #(
  .CAP_BYTES(CAP_BYTES), .LAT_PIX(LAT_PIX), .FILL_W(FILL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_clear(cfg_clear),
  .cfg_clr_at_start(cfg_clr_at_start), .cfg_underflow_trig(cfg_underflow_trig),
  .frame_start(frame_start), .active(active), .out_rd(out_rd),
  .in_ready(in_ready), .out_valid(out_valid), .fill_bytes(fill_bytes),
  .underflow(underflow)
);

// File: tb/pix_out_fifo_tb.sv
module pix_out_fifo_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable, cfg_clear, cfg_clr_at_start, cfg_underflow_trig;
  logic        cfg_wait_hstart, frame_start, line_start, active;
  logic [1:0]  cfg_fmt;
  logic        in_valid, in_ready, out_rd, out_valid, underflow;
  logic [23:0] in_pixel, out_pixel;
  logic [6:0]  fill_bytes;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pix_out_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_clear(cfg_clear),
    .cfg_fmt(cfg_fmt), .cfg_clr_at_start(cfg_clr_at_start),
    .cfg_underflow_trig(cfg_underflow_trig), .cfg_wait_hstart(cfg_wait_hstart),
    .frame_start(frame_start), .line_start(line_start), .active(active),
    .in_valid(in_valid), .in_pixel(in_pixel), .in_ready(in_ready),
    .out_rd(out_rd), .out_pixel(out_pixel), .out_valid(out_valid),
    .fill_bytes(fill_bytes), .underflow(underflow)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); cfg_clear = 1'b1;
    @(negedge clk); cfg_clear = 1'b0;
  endtask

  // push continuously until in_ready drops; returns accepted count
  task automatic fill_all(input logic [23:0] base, output int n);
    n = 0;
    for (int g = 0; g < 100; g++) begin
      @(negedge clk);
      if (!in_ready) break;
      in_pixel = base + 24'(n);
      in_valid = 1'b1;
      n++;
    end
    in_valid = 1'b0;
  endtask

  task automatic push_n(input logic [23:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_pixel = base + 24'(i);
      in_valid = 1'b1;
    end
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic rd_one(string req, logic [23:0] exp);
    @(negedge clk); out_rd = 1'b1; active = 1'b1;
    @(negedge clk); out_rd = 1'b0; active = 1'b0;
    chk({req, " out_valid"}, int'(out_valid), 1);
    chk({req, " out_pixel"}, int'(out_pixel), int'(exp));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 fill", int'(fill_bytes), 0);
    chk("R1 underflow", int'(underflow), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 0);
  endtask

  task automatic t_disabled();
    cfg_enable = 1'b0;
    push_n(24'h000100, 3);
    chk("R10 fill while disabled", int'(fill_bytes), 0);
    chk("R10 in_ready while disabled", int'(in_ready), 0);
  endtask

  task automatic t_fmt(logic [1:0] f, int exp_n, int bpp, logic [23:0] base);
    int n;
    cfg_enable = 1'b1;
    cfg_fmt = f;
    fill_all(base, n);
    chk("R2 pixels accepted", n, exp_n);
    chk("R3 fill bytes", int'(fill_bytes), exp_n * bpp);
    chk("R2 in_ready low at threshold", int'(in_ready), 0);
    for (int i = 0; i < exp_n; i++) rd_one("R4 order", base + 24'(i));
    chk("R4 drained", int'(fill_bytes), 0);
  endtask

  task automatic t_rescale();
    cfg_fmt = 2'b00;
    push_n(24'h000300, 10);
    chk("R3 16-bit bytes", int'(fill_bytes), 20);
    @(negedge clk); cfg_fmt = 2'b10;
    @(negedge clk);
    chk("R3 rescaled bytes", int'(fill_bytes), 30);
    chk("R2 ready below 24-bit threshold", int'(in_ready), 1);
    do_clear();
  endtask

  task automatic t_gating();
    push_n(24'h000400, 2);
    @(negedge clk); out_rd = 1'b1; active = 1'b0;
    @(negedge clk);
    chk("R5 inactive no pop", int'(fill_bytes), 6);
    chk("R5 inactive no valid", int'(out_valid), 0);
    cfg_enable = 1'b0; active = 1'b1;
    @(negedge clk);
    chk("R5 disabled no pop", int'(fill_bytes), 6);
    chk("R5 disabled no valid", int'(out_valid), 0);
    out_rd = 1'b0; active = 1'b0; cfg_enable = 1'b1;
    rd_one("R5 read resumes", 24'h000400);
    do_clear();
  endtask

  task automatic t_clear();
    push_n(24'h000500, 4);
    @(negedge clk); cfg_clear = 1'b1; in_valid = 1'b1; in_pixel = 24'hABCDEF;
    @(negedge clk); cfg_clear = 1'b0; in_valid = 1'b0;
    chk("R6 cleared with same-cycle write dropped", int'(fill_bytes), 0);
  endtask

  task automatic t_frame();
    push_n(24'h000600, 3);
    cfg_clr_at_start = 1'b0;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk("R7 frame start ignored when off", int'(fill_bytes), 9);
    cfg_clr_at_start = 1'b1;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    chk("R7 frame start clears", int'(fill_bytes), 0);
    cfg_clr_at_start = 1'b0;
  endtask

  task automatic t_underflow();
    cfg_underflow_trig = 1'b0;
    @(negedge clk); out_rd = 1'b1; active = 1'b1;
    @(negedge clk); out_rd = 1'b0; active = 1'b0;
    chk("R8 no flag with trigger off", int'(underflow), 0);
    cfg_underflow_trig = 1'b1;
    @(negedge clk); out_rd = 1'b1; active = 1'b1;
    @(negedge clk); out_rd = 1'b0; active = 1'b0;
    chk("R8 flag set", int'(underflow), 1);
    chk("R8 no valid on empty read", int'(out_valid), 0);
    push_n(24'h000700, 1);
    rd_one("R8 read after underflow", 24'h000700);
    chk("R8 flag sticky", int'(underflow), 1);
    do_clear();
    chk("R6 clear resets flag", int'(underflow), 0);
  endtask

  task automatic t_hstart();
    cfg_wait_hstart = 1'b1;
    do_clear();
    push_n(24'h000800, 2);
    @(negedge clk); out_rd = 1'b1; active = 1'b1;
    @(negedge clk); out_rd = 1'b0; active = 1'b0;
    chk("R9 read held before line start", int'(fill_bytes), 6);
    chk("R9 no valid before line start", int'(out_valid), 0);
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    rd_one("R9 read after line start", 24'h000800);
    do_clear();
    @(negedge clk); out_rd = 1'b1; active = 1'b1;
    @(negedge clk); out_rd = 1'b0; active = 1'b0;
    chk("R9 no underflow while held", int'(underflow), 0);
    cfg_wait_hstart = 1'b0;
    cfg_underflow_trig = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_enable = 0; cfg_clear = 0; cfg_fmt = 2'b10; cfg_clr_at_start = 0;
    cfg_underflow_trig = 0; cfg_wait_hstart = 0; frame_start = 0;
    line_start = 0; active = 0; in_valid = 0; in_pixel = '0; out_rd = 0;
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_disabled();
    t_fmt(2'b00, 26, 2, 24'h010000);
    t_fmt(2'b01, 17, 3, 24'h020000);
    t_fmt(2'b10, 16, 3, 24'h030000);
    t_fmt(2'b11, 16, 3, 24'h040000);
    t_rescale();
    t_gating();
    t_clear();
    t_frame();
    t_underflow();
    t_hstart();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule